// File: doc/BRIEF.md
# Fixed-Latency Completion Pipeline with Write-Port Budget

This block tracks instructions from issue to register write-back. An accepted issue carries a destination mask with one bit per architectural register. The mask is placed a fixed number of cycles ahead of completion and moves one slot closer each cycle. When a mask reaches the head slot, its registers compete for a small number of register-file write ports. Registers that win a port are reported on the retire output, so a scoreboard can clear their pending state.

If the head slot asks for more registers than there are ports, the block raises stall. The granted registers still retire that cycle and are removed from the head slot. Every other slot holds its contents, and no new issue is taken. The pipeline advances again in the first cycle where the remaining head demand fits within the port budget. Operand values and arithmetic are not modelled; only register identities move through the block.

Top module: `latency_pipe`

## Requirements
- R1: After a synchronous active-low reset, every slot is empty: retire_o is all zero and stall_o is low until a new issue arrives.
- R2: An issue accepted in cycle t with a single-bit mask (bit n = register n) shows that bit on retire_o in cycle t+LAT, where LAT defaults to 2, and in no other cycle.
- R3: Issues accepted in consecutive cycles retire in consecutive cycles, in issue order.
- R4: A head mask with k set bits drains over ceil(k/WPORTS) cycles (WPORTS defaults to 1), with one grant of at most WPORTS registers per cycle.
- R5: stall_o is high exactly when the head slot holds more pending registers than WPORTS; retire_o is then non-zero.
- R6: An issue presented while stall_o is high is discarded and never appears on retire_o.
- R7: While stall_o is high, the non-head slots keep their contents, so an instruction behind a stalled head retires one cycle later per stall cycle.
- R8: Within the head slot, ports are granted to the lowest-numbered pending registers first, so successive grants carry strictly higher register numbers.
- R9: An issue with valid low, or with an all-zero mask, has no effect on retire_o or stall_o.
- R10: retire_o never has more than WPORTS bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid_i | input | 1 | An instruction is offered for issue this cycle |
| issue_mask_i | input | 32 | Destination registers of the offered instruction, bit n = register n |
| retire_o | output | 32 | Registers written back this cycle |
| stall_o | output | 1 | Head demand exceeds the write ports; pipeline frozen, issue refused |

## Verification
The assertions assume that the upstream logic honours stall_o and does not expect a refused issue to be held over. They also assume that a mask is never re-issued while its registers are still in flight. The stimulus drives new issues only on falling edges, and leaves every refused issue out of the expected retire stream. Multi-bit masks are the only source of stalls. The bench uses them to create stalls of one and two cycles, with an instruction queued behind the stalled head and an issue landing on the release cycle.

// File: rtl/latency_pipe_pkg.sv
// Package: shared register-mask type for the completion pipeline.
// Assumes one bit per architectural register.
package latency_pipe_pkg;
    parameter int unsigned REG_W = 32;
    typedef logic [REG_W-1:0] regmask_t;
endpackage

// File: rtl/port_grant.sv
// Module: port_grant
// Grants up to NPORT write ports to the lowest-numbered set bits of req_i.
// Purely combinational; assumes NPORT >= 1.
module port_grant
    import latency_pipe_pkg::*;
#(
    parameter int unsigned NPORT = 1
) (
    input  regmask_t req_i,
    output regmask_t grant_o,
    output logic     short_o
);
    regmask_t rem;
    regmask_t low;

    // Peel the lowest pending bit once per port.
    always_comb begin
        rem     = req_i;
        grant_o = '0;
        low     = '0;
        for (int p = 0; p < int'(NPORT); p++) begin
            low     = rem & (~rem + regmask_t'(1));
            grant_o = grant_o | low;
            rem     = rem & ~low;
        end
        short_o = |rem;
    end
endmodule

// File: rtl/countdown_slots.sv
// Module: countdown_slots
// Holds DEPTH merged destination masks, slot 0 being the completing one.
// On advance every slot shifts one step toward slot 0 and a new mask is
// merged into slot LAT-1; on hold only the granted bits leave slot 0.
// Assumes 1 <= LAT <= DEPTH.
module countdown_slots
    import latency_pipe_pkg::*;
#(
    parameter int unsigned DEPTH = 3,
    parameter int unsigned LAT   = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     advance_i,
    input  regmask_t granted_i,
    input  logic     ins_valid_i,
    input  regmask_t ins_mask_i,
    output regmask_t head_o
);
    localparam int unsigned INS_SLOT = LAT - 1;

    regmask_t slot_q [DEPTH];

    for (genvar k = 0; k < int'(DEPTH); k++) begin : g_slot
        regmask_t from_above;
        regmask_t ins_here;

        // Contents arriving from the next-farther slot on an advance.
        if (k == int'(DEPTH) - 1) begin : g_top
            assign from_above = '0;
        end else begin : g_mid
            assign from_above = slot_q[k+1];
        end

        // New issue mask merged only at the insertion slot.
        if (k == int'(INS_SLOT)) begin : g_ins
            assign ins_here = ins_valid_i ? ins_mask_i : '0;
        end else begin : g_noins
            assign ins_here = '0;
        end

        // Slot register: shift on advance, drain head on hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[k] <= '0;
            end else if (advance_i) begin
                slot_q[k] <= from_above | ins_here;
            end else if (k == 0) begin
                slot_q[k] <= slot_q[k] & ~granted_i;
            end
        end
    end

    assign head_o = slot_q[0];
endmodule

// File: rtl/latency_pipe.sv
// Module: latency_pipe (top)
// Fixed-latency completion tracker whose write-back is limited to WPORTS
// registers per cycle; a shortfall freezes the whole pipeline.
// Assumes the issuer drops its offer whenever stall_o is high.
module latency_pipe
    import latency_pipe_pkg::*;
#(
    parameter int unsigned DEPTH  = 3,
    parameter int unsigned LAT    = 2,
    parameter int unsigned WPORTS = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid_i,
    input  logic [REG_W-1:0]     issue_mask_i,
    output logic [REG_W-1:0]     retire_o,
    output logic                 stall_o
);
    regmask_t head;
    regmask_t grant;
    logic     short;
    logic     accept;

    port_grant #(.NPORT(WPORTS)) u_grant (
        .req_i   (head),
        .grant_o (grant),
        .short_o (short)
    );

    // Issue is taken only while the pipeline is free to move.
    assign accept = issue_valid_i & ~short;

    countdown_slots #(.DEPTH(DEPTH), .LAT(LAT)) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance_i   (~short),
        .granted_i   (grant),
        .ins_valid_i (accept),
        .ins_mask_i  (issue_mask_i),
        .head_o      (head)
    );

    assign retire_o = grant;
    assign stall_o  = short;
endmodule

// Checker: port-level properties of the completion pipeline.
module latency_pipe_chk
    import latency_pipe_pkg::*;
#(
    parameter int unsigned WPORTS = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] retire_o,
    input logic             stall_o
);
    // R10: write-port budget never exceeded.
    a_r10_port_budget: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(retire_o) <= WPORTS);

    // R5: a stall always comes with a grant this cycle.
    a_r5_stall_grants: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (retire_o != '0));

    // R4: leftover demand after a stall is written the next cycle.
    a_r4_drain_continues: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (retire_o != '0));

    // R8: successive grants from a stalled head go to higher registers.
    a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (retire_o > $past(retire_o)));
endmodule

bind latency_pipe latency_pipe_chk #(.WPORTS(WPORTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .retire_o (retire_o),
    .stall_o  (stall_o)
);

// File: tb/latency_pipe_tb.sv
module latency_pipe_tb;
    localparam int PERIOD = 10;
    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid_i = 1'b0;
    logic [31:0] issue_mask_i = '0;
    logic [31:0] retire_o;
    logic        stall_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    latency_pipe u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_valid_i (issue_valid_i),
        .issue_mask_i  (issue_mask_i),
        .retire_o      (retire_o),
        .stall_o       (stall_o)
    );

    always #(PERIOD/2) clk = ~clk;

    // Row: {valid, mask[31:0], expected retire[31:0], expected stall}
    localparam logic [65:0] VEC [NV] = '{
        {1'b1, 32'h0000_0010, 32'h0000_0000, 1'b0},  // 0  issue r4
        {1'b1, 32'h0000_0200, 32'h0000_0000, 1'b0},  // 1  issue r9
        {1'b0, 32'h0000_0000, 32'h0000_0010, 1'b0},  // 2  r4 retires (R2)
        {1'b0, 32'h0000_0000, 32'h0000_0200, 1'b0},  // 3  r9 next (R3)
        {1'b1, 32'h8001_0001, 32'h0000_0000, 1'b0},  // 4  issue r0,r16,r31
        {1'b1, 32'h0000_0080, 32'h0000_0000, 1'b0},  // 5  issue r7
        {1'b1, 32'h0000_0004, 32'h0000_0001, 1'b1},  // 6  r0, stall; r2 dropped (R6)
        {1'b0, 32'h0000_0000, 32'h0001_0000, 1'b1},  // 7  r16, stall (R8)
        {1'b1, 32'h0000_0008, 32'h8000_0000, 1'b0},  // 8  r31, release; r3 taken
        {1'b0, 32'h0000_0000, 32'h0000_0080, 1'b0},  // 9  r7 delayed (R7)
        {1'b0, 32'h0000_0000, 32'h0000_0008, 1'b0},  // 10 r3
        {1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0},  // 11 r2 never shows (R6)
        {1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0},  // 12 empty mask (R9)
        {1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0},  // 13
        {1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0},  // 14 empty mask gone (R9)
        {1'b0, 32'h0000_0020, 32'h0000_0000, 1'b0},  // 15 mask, valid low (R9)
        {1'b1, 32'h0000_0006, 32'h0000_0000, 1'b0},  // 16 issue r1,r2
        {1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0},  // 17 r5 absent (R9)
        {1'b0, 32'h0000_0000, 32'h0000_0002, 1'b1}   // 18 r1, stall (R5)
    };

    function automatic string row_tag(int k);
        case (k)
            2:           return "R2";
            3:           return "R3";
            6, 11:       return "R6";
            7:           return "R8";
            8, 9, 10:    return "R7";
            12, 13, 14, 15, 17: return "R9";
            18:          return "R5";
            default:     return "R4";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] exp_r, logic exp_s);
        checks++;
        if (retire_o !== exp_r || stall_o !== exp_s) begin
            errors++;
            $display("FAIL %s: retire=%h stall=%b expected retire=%h stall=%b",
                     tag, retire_o, stall_o, exp_r, exp_s);
        end
    endtask

    task automatic drive_idle();
        @(negedge clk);
        issue_valid_i = 1'b0;
        issue_mask_i  = '0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", 32'h0, 1'b0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            issue_valid_i = VEC[k][65];
            issue_mask_i  = VEC[k][64:33];
            #1;
            check(row_tag(k), VEC[k][32:1], VEC[k][0]);
        end

        // R4: second bit of the r1,r2 head drains, pipeline released.
        drive_idle();
        check("R4", 32'h0000_0004, 1'b0);
        drive_idle();
        check("R4", 32'h0, 1'b0);

        // R1: reset mid-drain clears leftover demand.
        @(negedge clk);
        issue_valid_i = 1'b1;
        issue_mask_i  = 32'h0000_0C00;
        drive_idle();
        drive_idle();
        check("R5", 32'h0000_0400, 1'b1);
        rst_n = 1'b0;
        drive_idle();
        check("R1", 32'h0, 1'b0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            drive_idle();
            check("R1", 32'h0, 1'b0);
        end

        // R10: a wide mask never retires more than one register per cycle.
        @(negedge clk);
        issue_valid_i = 1'b1;
        issue_mask_i  = 32'hF000_0000;
        drive_idle();
        for (int k = 0; k < 4; k++) begin
            drive_idle();
            check("R10", 32'h1000_0000 << k, (k < 3) ? 1'b1 : 1'b0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule